// File: doc/BRIEF.md
# Segment-Guarded Control Register Bank

This block is a small map of eight byte-wide control and status registers placed beside a processor. The core selects a register with a 3-bit index. It writes the selected register on a clock edge by raising a strobe with a data byte. It reads any register through a combinational port, so the value is available in the same cycle.

Two of the registers hold execute-permission masks. Together they cover sixteen memory segments of 16 bytes each. A 4-bit segment number on a dedicated input returns an executable flag at once, which lets fetch logic block code running from a segment that is not allowed.

The rest of the map holds the following:
- a general-purpose output byte;
- a view of an input byte;
- a 16-bit up-counter whose two bytes are writable;
- a status/control byte that enables the counter and drives six signal lines and an interrupt line to a host;
- a view of a byte that the host supplies.

Top module: `csr_bank`

## Requirements
- R1: After reset, every writable register reads 0x00 with the default parameters. This covers both masks, the output byte, both counter bytes and the status byte. As a result `seg_exec` is 0 for every segment, and `pin_out`, `host_sig` and `host_irq` are all 0.
- R2: For segments 0 to 7, `seg_exec` is combinationally equal to bit `seg_num` of the mask at index 0.
- R3: For segments 8 to 15, `seg_exec` is combinationally equal to bit `seg_num`-8 of the mask at index 1. For example, writing 0x0F there makes segments 8 to 11 executable and no others in that half.
- R4: A write with `csr_we`=1 takes effect at the next rising edge. After that edge, reading the same index returns the written byte on `csr_rdata`. This applies to indices 0, 1, 3, 4, 5 and 6.
- R5: `csr_rdata` shows `pin_in` combinationally when the index is 2, and `host_byte` when the index is 7.
- R6: `pin_out` equals the register at index 3 and follows a write on the edge that takes the write.
- R7: The byte at index 6 is laid out as follows: bit 0 drives `host_irq`, bit 1 is the counter enable, and bits 7:2 drive `host_sig[5:0]`.
- R8: While the counter enable is 1, the counter {index 5, index 4} rises by one on every edge. A carry out of the low byte goes into the high byte, and 0xFFFF goes to 0x0000.
- R9: While the counter enable is 0 and neither counter byte is written, the counter holds its value.
- R10: A write to one counter byte loads that byte instead of its increment on that edge. The other byte still counts, and the high byte takes the carry from the low byte's value before the write.
- R11: Writes to indices 2 and 7 change no register: the masks, the output byte, the counter and the status byte are all left as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| csr_idx | input | 3 | Register index for both reads and writes |
| csr_we | input | 1 | Write strobe |
| csr_wdata | input | 8 | Write data |
| csr_rdata | output | 8 | Combinational read data for `csr_idx` |
| seg_num | input | 4 | Segment number to test for execute permission |
| seg_exec | output | 1 | 1 when segment `seg_num` is executable |
| pin_in | input | 8 | External input byte, read at index 2 |
| pin_out | output | 8 | External output byte from index 3 |
| host_sig | output | 6 | Host signal lines from status bits 7:2 |
| host_irq | output | 1 | Host interrupt from status bit 0 |
| host_byte | input | 8 | Host-supplied byte, read at index 7 |

## Verification
Results fall into two groups by when they become visible:
- Reads and the executable flag are combinational. The bench therefore samples them one time step after it changes the index, the segment number or an input byte, in the low phase of the clock.
- A write, and its effect on the output lines, appears after exactly one rising edge. The bench drives the write in the low phase and samples at the following falling edge.

For the counter, the bench counts edges explicitly. The edge that takes the enabling status write does not yet count. Every later edge counts, including the edge that takes the disabling write. The counter is then read back only while it is stopped, so the expected value is the preset plus that edge count.

// File: rtl/csr_pkg.sv
`timescale 1ns/1ps
package csr_pkg;
  localparam int IDX_W   = 3;
  localparam int NUM_CSR = 1 << IDX_W;
  typedef logic [IDX_W-1:0] csr_idx_t;

  // Register indices; decoded by the core and by the host-side logic.
  localparam csr_idx_t IDX_EXE_LO = 3'd0;
  localparam csr_idx_t IDX_EXE_HI = 3'd1;
  localparam csr_idx_t IDX_PIN_IN = 3'd2;
  localparam csr_idx_t IDX_PIN_OUT = 3'd3;
  localparam csr_idx_t IDX_CNT_LO = 3'd4;
  localparam csr_idx_t IDX_CNT_HI = 3'd5;
  localparam csr_idx_t IDX_STATUS = 3'd6;
  localparam csr_idx_t IDX_HOST   = 3'd7;

  // Status byte field positions.
  localparam int ST_IRQ_BIT = 0;
  localparam int ST_CNT_BIT = 1;
  localparam int ST_SIG_LSB = 2;
endpackage

// File: rtl/csr_seg_guard.sv
`timescale 1ns/1ps
module csr_seg_guard #(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] LO_INIT = '0,
  parameter logic [DATA_W-1:0] HI_INIT = '0,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wdata,
  input  logic [BIT_W:0]    seg_num,
  output logic [DATA_W-1:0] exe_lo,
  output logic [DATA_W-1:0] exe_hi,
  output logic              seg_exec
);
  // Upper segment-number bit picks the mask, the rest picks the bit.
  function automatic logic seg_pick(input logic [DATA_W-1:0] lo,
                                    input logic [DATA_W-1:0] hi,
                                    input logic [BIT_W:0]    seg);
    logic [DATA_W-1:0] bank;
    bank = seg[BIT_W] ? hi : lo;
    return bank[seg[BIT_W-1:0]];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exe_lo <= LO_INIT;
      exe_hi <= HI_INIT;
    end else begin
      if (wr_lo) exe_lo <= wdata;
      if (wr_hi) exe_hi <= wdata;
    end
  end

  assign seg_exec = seg_pick(exe_lo, exe_hi, seg_num);
endmodule

// File: rtl/csr_tick_counter.sv
`timescale 1ns/1ps
module csr_tick_counter #(
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cnt_lo,
  output logic [DATA_W-1:0] cnt_hi
);
  // Per-byte next value: a written byte loads, otherwise it counts;
  // the high byte takes the carry of the pre-write low byte.
  function automatic logic [CNT_W-1:0] tick_next(input logic [DATA_W-1:0] lo,
                                                 input logic [DATA_W-1:0] hi,
                                                 input logic [DATA_W-1:0] wd,
                                                 input logic              inc,
                                                 input logic              ld_lo,
                                                 input logic              ld_hi);
    logic              carry;
    logic [DATA_W-1:0] nlo;
    logic [DATA_W-1:0] nhi;
    carry = inc && (lo == {DATA_W{1'b1}});
    nlo   = ld_lo ? wd : lo + DATA_W'(inc);
    nhi   = ld_hi ? wd : hi + DATA_W'(carry);
    return {nhi, nlo};
  endfunction

  logic [CNT_W-1:0] nxt;
  assign nxt = tick_next(cnt_lo, cnt_hi, wdata, en, wr_lo, wr_hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_lo <= '0;
      cnt_hi <= '0;
    end else begin
      cnt_lo <= nxt[DATA_W-1:0];
      cnt_hi <= nxt[CNT_W-1:DATA_W];
    end
  end
endmodule

// File: rtl/csr_read_mux.sv
`timescale 1ns/1ps
module csr_read_mux
  import csr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  csr_idx_t                  idx,
  input  logic [NUM_CSR*DATA_W-1:0] regs,
  output logic [DATA_W-1:0]         rdata
);
  always_comb rdata = regs[idx*DATA_W +: DATA_W];
endmodule

// File: rtl/csr_bank.sv
`timescale 1ns/1ps
module csr_bank
  import csr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] EXE_LO_INIT = '0,
  parameter logic [DATA_W-1:0] EXE_HI_INIT = '0,
  localparam int SEG_W = $clog2(DATA_W) + 1,
  localparam int SIG_W = DATA_W - ST_SIG_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  csr_idx,
  input  logic              csr_we,
  input  logic [DATA_W-1:0] csr_wdata,
  output logic [DATA_W-1:0] csr_rdata,
  input  logic [SEG_W-1:0]  seg_num,
  output logic              seg_exec,
  input  logic [DATA_W-1:0] pin_in,
  output logic [DATA_W-1:0] pin_out,
  output logic [SIG_W-1:0]  host_sig,
  output logic              host_irq,
  input  logic [DATA_W-1:0] host_byte
);
  localparam int CNT_W = 2 * DATA_W;

  // One write-select line per index.
  logic [NUM_CSR-1:0] wr_sel;
  for (genvar gi = 0; gi < NUM_CSR; gi++) begin : g_wsel
    assign wr_sel[gi] = csr_we && (csr_idx == IDX_W'(gi));
  end

  logic [DATA_W-1:0] exe_lo, exe_hi, cnt_lo, cnt_hi;
  logic [DATA_W-1:0] out_q, stat_q;
  logic              cnt_en;
  logic [CNT_W-1:0]  cnt_q;

  csr_seg_guard #(
    .DATA_W (DATA_W),
    .LO_INIT(EXE_LO_INIT),
    .HI_INIT(EXE_HI_INIT)
  ) guard_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_lo   (wr_sel[IDX_EXE_LO]),
    .wr_hi   (wr_sel[IDX_EXE_HI]),
    .wdata   (csr_wdata),
    .seg_num (seg_num),
    .exe_lo  (exe_lo),
    .exe_hi  (exe_hi),
    .seg_exec(seg_exec)
  );

  assign cnt_en = stat_q[ST_CNT_BIT];

  csr_tick_counter #(.DATA_W(DATA_W)) cnt_i (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (cnt_en),
    .wr_lo (wr_sel[IDX_CNT_LO]),
    .wr_hi (wr_sel[IDX_CNT_HI]),
    .wdata (csr_wdata),
    .cnt_lo(cnt_lo),
    .cnt_hi(cnt_hi)
  );

  assign cnt_q = {cnt_hi, cnt_lo};

  // Output byte and status byte. Indices 2 and 7 have no storage.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      stat_q <= '0;
    end else begin
      if (wr_sel[IDX_PIN_OUT]) out_q  <= csr_wdata;
      if (wr_sel[IDX_STATUS])  stat_q <= csr_wdata;
    end
  end

  assign pin_out  = out_q;
  assign host_irq = stat_q[ST_IRQ_BIT];
  assign host_sig = stat_q[DATA_W-1:ST_SIG_LSB];

  logic [NUM_CSR*DATA_W-1:0] rd_vec;
  assign rd_vec = {host_byte, stat_q, cnt_hi, cnt_lo, out_q, pin_in, exe_hi, exe_lo};

  csr_read_mux #(.DATA_W(DATA_W)) rmux_i (
    .idx  (csr_idx),
    .regs (rd_vec),
    .rdata(csr_rdata)
  );
endmodule

// File: rtl/csr_bank_chk.sv
`timescale 1ns/1ps
module csr_bank_chk
  import csr_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int SEG_W = $clog2(DATA_W) + 1,
  localparam int SIG_W = DATA_W - ST_SIG_LSB,
  localparam int CNT_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [IDX_W-1:0]  csr_idx,
  input logic              csr_we,
  input logic [DATA_W-1:0] csr_wdata,
  input logic [DATA_W-1:0] csr_rdata,
  input logic [SEG_W-1:0]  seg_num,
  input logic              seg_exec,
  input logic [DATA_W-1:0] pin_in,
  input logic [DATA_W-1:0] pin_out,
  input logic [SIG_W-1:0]  host_sig,
  input logic              host_irq,
  input logic              cnt_en,
  input logic [CNT_W-1:0]  cnt_q
);
  logic cnt_wr;
  assign cnt_wr = csr_we && (csr_idx == IDX_CNT_LO || csr_idx == IDX_CNT_HI);

  AST_EXEC_LOW_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_idx == IDX_EXE_LO && !seg_num[SEG_W-1]) |-> seg_exec == csr_rdata[seg_num[SEG_W-2:0]]); // R2
  AST_EXEC_HIGH_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_idx == IDX_EXE_HI && seg_num[SEG_W-1]) |-> seg_exec == csr_rdata[seg_num[SEG_W-2:0]]); // R3
  AST_INPUT_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_idx == IDX_PIN_IN) |-> csr_rdata == pin_in); // R5
  AST_OUT_PORT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_idx == IDX_PIN_OUT) |=> pin_out == $past(csr_wdata)); // R6
  AST_STATUS_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_idx == IDX_STATUS) |=> {host_sig, cnt_en, host_irq} == $past(csr_wdata)); // R7
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !cnt_wr) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1)); // R8
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !cnt_wr) |=> $stable(cnt_q)); // R9
  AST_CNT_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_idx == IDX_CNT_LO) |=> cnt_q[DATA_W-1:0] == $past(csr_wdata)); // R10
  AST_RO_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && (csr_idx == IDX_PIN_IN || csr_idx == IDX_HOST))
      |=> ($stable(pin_out) && $stable(host_sig) && $stable(host_irq))); // R11
endmodule

bind csr_bank csr_bank_chk #(.DATA_W(DATA_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .csr_idx  (csr_idx),
  .csr_we   (csr_we),
  .csr_wdata(csr_wdata),
  .csr_rdata(csr_rdata),
  .seg_num  (seg_num),
  .seg_exec (seg_exec),
  .pin_in   (pin_in),
  .pin_out  (pin_out),
  .host_sig (host_sig),
  .host_irq (host_irq),
  .cnt_en   (cnt_en),
  .cnt_q    (cnt_q)
);

// File: tb/csr_bank_tb_top.sv
`timescale 1ns/1ps
module csr_bank_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] csr_idx = '0;
  logic       csr_we = 1'b0;
  logic [7:0] csr_wdata = '0;
  logic [7:0] csr_rdata;
  logic [3:0] seg_num = '0;
  logic       seg_exec;
  logic [7:0] pin_in = '0;
  logic [7:0] pin_out;
  logic [5:0] host_sig;
  logic       host_irq;
  logic [7:0] host_byte = '0;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  csr_bank dut_i (
    .clk(clk), .rst_n(rst_n), .csr_idx(csr_idx), .csr_we(csr_we),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .seg_num(seg_num),
    .seg_exec(seg_exec), .pin_in(pin_in), .pin_out(pin_out),
    .host_sig(host_sig), .host_irq(host_irq), .host_byte(host_byte)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  // Called in the low phase; the write lands on the next rising edge.
  task automatic wr(input logic [2:0] idx, input logic [7:0] data);
    csr_we = 1'b1; csr_idx = idx; csr_wdata = data;
    @(posedge clk);
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [7:0] data);
    csr_idx = idx;
    #0.5;
    data = csr_rdata;
  endtask

  task automatic exec_at(input logic [3:0] seg, output logic f);
    seg_num = seg;
    #0.5;
    f = seg_exec;
  endtask

  task automatic read_cnt(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(3'd4, lo);
    rd(3'd5, hi);
    v = {hi, lo};
  endtask

  task automatic t_reset();
    logic [7:0] d; logic f;
    foreach (d[i]) begin end
    for (int i = 0; i < 8; i++) begin
      if (i == 2 || i == 7) continue;
      rd(3'(i), d);
      check("R1 reset readback", {8'h0, d}, 16'h0);
    end
    exec_at(4'd0, f);  check("R1 seg0 not executable", {15'h0, f}, 16'h0);
    exec_at(4'd9, f);  check("R1 seg9 not executable", {15'h0, f}, 16'h0);
    check("R1 pin_out", {8'h0, pin_out}, 16'h0);
    check("R1 host lines", {9'h0, host_sig, host_irq}, 16'h0);
  endtask

  task automatic t_exec_low();
    logic [7:0] d; logic f;
    wr(3'd0, 8'hA5);
    rd(3'd0, d);
    check("R4 low mask readback", {8'h0, d}, 16'h00A5);
    for (int s = 0; s < 8; s++) begin
      exec_at(4'(s), f);
      check("R2 low segment flag", {15'h0, f}, {15'h0, 1'((8'hA5 >> s) & 1)});
    end
  endtask

  task automatic t_exec_high();
    logic [7:0] d; logic f;
    wr(3'd1, 8'h0F);
    rd(3'd1, d);
    check("R4 high mask readback", {8'h0, d}, 16'h000F);
    for (int s = 8; s < 16; s++) begin
      exec_at(4'(s), f);
      check("R3 high segment flag", {15'h0, f}, {15'h0, (s < 12) ? 1'b1 : 1'b0});
    end
    exec_at(4'd1, f);
    check("R2 low mask kept after high write", {15'h0, f}, 16'h0);
  endtask

  task automatic t_ports();
    logic [7:0] d;
    pin_in = 8'h3C; host_byte = 8'h96;
    rd(3'd2, d); check("R5 input view", {8'h0, d}, 16'h003C);
    rd(3'd7, d); check("R5 host view", {8'h0, d}, 16'h0096);
    pin_in = 8'hC3;
    rd(3'd2, d); check("R5 input view follows", {8'h0, d}, 16'h00C3);
    wr(3'd3, 8'h5A);
    check("R6 pin_out", {8'h0, pin_out}, 16'h005A);
    rd(3'd3, d); check("R4 output readback", {8'h0, d}, 16'h005A);
  endtask

  task automatic t_status();
    logic [7:0] d;
    wr(3'd6, 8'hB5);
    check("R7 irq bit", {15'h0, host_irq}, 16'h1);
    check("R7 signal bits", {10'h0, host_sig}, 16'h002D);
    rd(3'd6, d); check("R4 status readback", {8'h0, d}, 16'h00B5);
    wr(3'd6, 8'h00);
    check("R7 lines cleared", {9'h0, host_sig, host_irq}, 16'h0);
  endtask

  task automatic t_count();
    logic [15:0] v;
    wr(3'd4, 8'hFD); wr(3'd5, 8'h12);
    wr(3'd6, 8'h02);
    repeat (4) @(negedge clk);
    wr(3'd6, 8'h00);
    read_cnt(v);
    check("R8 count with carry", v, 16'h1302);
    repeat (5) @(negedge clk);
    read_cnt(v);
    check("R9 hold while disabled", v, 16'h1302);
    wr(3'd4, 8'hFE); wr(3'd5, 8'hFF);
    wr(3'd6, 8'h02);
    repeat (1) @(negedge clk);
    wr(3'd6, 8'h00);
    read_cnt(v);
    check("R8 wrap to zero", v, 16'h0000);
  endtask

  task automatic t_priority();
    logic [15:0] v;
    wr(3'd4, 8'hFF); wr(3'd5, 8'h20);
    wr(3'd6, 8'h02);
    wr(3'd4, 8'h40);
    wr(3'd6, 8'h00);
    read_cnt(v);
    check("R10 low write wins, carry kept", v, 16'h2141);
    wr(3'd6, 8'h02);
    wr(3'd5, 8'h05);
    wr(3'd6, 8'h00);
    read_cnt(v);
    check("R10 high write wins, low counts", v, 16'h0543);
  endtask

  task automatic t_readonly();
    logic [7:0] d; logic [15:0] v;
    wr(3'd3, 8'h77);
    wr(3'd6, 8'hB5);
    wr(3'd2, 8'hFF);
    wr(3'd7, 8'h00);
    check("R11 pin_out untouched", {8'h0, pin_out}, 16'h0077);
    check("R11 host lines untouched", {9'h0, host_sig, host_irq}, {9'h0, 6'h2D, 1'b1});
    rd(3'd0, d); check("R11 low mask untouched", {8'h0, d}, 16'h00A5);
    rd(3'd1, d); check("R11 high mask untouched", {8'h0, d}, 16'h000F);
    read_cnt(v); check("R11 counter untouched", v, 16'h0543);
  endtask

  initial begin
    #(4 * 100000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_exec_low();
    t_exec_high();
    t_ports();
    t_status();
    t_count();
    t_priority();
    t_readonly();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule